// File: doc/BRIEF.md
# I2C Bus-Clear Recovery Sequencer

This block frees an I2C bus whose data line is held low by a target that stopped in the middle of a byte. When a recovery is requested, the sequencer first tells the controller to answer with a not-acknowledge. It then clocks the stuck target out with a fixed train of nine open-drain SCL pulses and closes with a STOP condition. The surrounding controller invokes it after a bus-busy timeout or a transfer timeout, and re-initializes itself once the done pulse arrives.

Timing is derived from the system clock. A prescaler turns `TICKS_PER_US` clock cycles into one microsecond tick. Every bus phase, whether SCL low, SCL released or the STOP hold, lasts `INTERVAL_US` ticks. Both lines are only ever pulled low or released. Nothing drives them high.

Top module: `i2c_bus_clear`

## Requirements
- R1: In the first cycle after a start strobe is accepted, `busy_o` and `nack_force_o` are 1, both drive enables are 0, and no SCL pulse has begun. `nack_force_o` then stays 1 until the cycle in which `done_o` is 1.
- R2: Each recovery produces exactly `NUM_PULSES` (default 9) low pulses on `scl_low_o`.
- R3: Each SCL low phase (`scl_low_o`=1) lasts exactly `TICKS_PER_US*INTERVAL_US` clock cycles. The first one begins in the second cycle after the strobe is sampled.
- R4: Each SCL released phase after a low phase lasts exactly `TICKS_PER_US*INTERVAL_US` cycles. During it, both drive enables are 0 and `busy_o` is 1.
- R5: SCL is never actively driven high. `scl_low_o` and `sda_low_o` are never 1 in the same cycle.
- R6: After the last released phase, `sda_low_o` is 1 for `TICKS_PER_US*INTERVAL_US` cycles while SCL is released. It is then released, which forms the STOP.
- R7: `done_o` is 1 for exactly one cycle, in the cycle right after the STOP hold ends. `busy_o` falls in that same cycle, and all outputs are 0 in the following cycle.
- R8: A start strobe that arrives while `busy_o` is 1 is ignored. The sequence timing is unchanged, and no new recovery follows the done pulse.
- R9: During and right after reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Recovery request strobe, accepted only while idle |
| nack_force_o | output | 1 | Forces the controller to send not-acknowledge |
| scl_low_o | output | 1 | Open-drain SCL pull-down enable |
| sda_low_o | output | 1 | Open-drain SDA pull-down enable |
| busy_o | output | 1 | Recovery in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with `TICKS_PER_US`=2 and `INTERVAL_US`=3. With these values every phase is six cycles long and a full recovery takes about 120 cycles. The whole waveform can therefore be compared cycle by cycle, including every prescaler wrap and every microsecond-counter wrap at the phase boundaries. The pulse count stays at its default of nine, so the stop decision at the ninth released phase is exercised exactly as it will be used.

// File: rtl/i2cbc_pkg.sv
package i2cbc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ARM  = 3'd1,
    ST_LOW  = 3'd2,
    ST_HIGH = 3'd3,
    ST_STOP = 3'd4
  } bc_state_e;
endpackage

// File: rtl/i2cbc_tick.sv
// Microsecond prescaler: one-cycle tick every TICKS_PER_US cycles while run is set.
module i2cbc_tick #(
  parameter int TICKS_PER_US = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (TICKS_PER_US > 1) ? $clog2(TICKS_PER_US) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_US - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/i2cbc_interval.sv
// Counts microsecond ticks; flags the last cycle of each INTERVAL_US window.
module i2cbc_interval #(
  parameter int INTERVAL_US = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  input  logic tick_i,
  output logic phase_end_o
);
  localparam int UW = (INTERVAL_US > 1) ? $clog2(INTERVAL_US) : 1;
  localparam logic [UW-1:0] LAST = UW'(INTERVAL_US - 1);

  logic [UW-1:0] us_q;

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      us_q <= '0;
    end else if (tick_i) begin
      us_q <= (us_q == LAST) ? '0 : us_q + 1'b1;
    end
  end

  assign phase_end_o = tick_i && (us_q == LAST);
endmodule

// File: rtl/i2cbc_ctrl.sv
// Sequencing: arm NACK, NUM_PULSES low/release pairs, STOP hold, done.
module i2cbc_ctrl
  import i2cbc_pkg::*;
#(
  parameter int NUM_PULSES = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic phase_end_i,
  output logic run_o,
  output logic nack_force_o,
  output logic scl_low_o,
  output logic sda_low_o,
  output logic busy_o,
  output logic done_o
);
  localparam int PW = (NUM_PULSES > 1) ? $clog2(NUM_PULSES) : 1;
  localparam logic [PW-1:0] LAST_PULSE = PW'(NUM_PULSES - 1);

  bc_state_e     state_q, state_d;
  logic [PW-1:0] pulse_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_ARM;
      ST_ARM:  state_d = ST_LOW;
      ST_LOW:  if (phase_end_i) state_d = ST_HIGH;
      ST_HIGH: if (phase_end_i) state_d = (pulse_q == LAST_PULSE) ? ST_STOP : ST_LOW;
      ST_STOP: if (phase_end_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign run_o = (state_q == ST_LOW) || (state_q == ST_HIGH) || (state_q == ST_STOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      pulse_q      <= '0;
      nack_force_o <= 1'b0;
      scl_low_o    <= 1'b0;
      sda_low_o    <= 1'b0;
      busy_o       <= 1'b0;
      done_o       <= 1'b0;
    end else begin
      state_q      <= state_d;
      if (state_q == ST_ARM) begin
        pulse_q <= '0;
      end else if (state_q == ST_HIGH && phase_end_i) begin
        pulse_q <= pulse_q + 1'b1;
      end
      nack_force_o <= (state_d != ST_IDLE);
      busy_o       <= (state_d != ST_IDLE);
      scl_low_o    <= (state_d == ST_LOW);
      sda_low_o    <= (state_d == ST_STOP);
      done_o       <= (state_q == ST_STOP) && phase_end_i;
    end
  end
endmodule

// File: rtl/i2c_bus_clear.sv
module i2c_bus_clear #(
  parameter int TICKS_PER_US = 50,
  parameter int INTERVAL_US  = 20,
  parameter int NUM_PULSES   = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic nack_force_o,
  output logic scl_low_o,
  output logic sda_low_o,
  output logic busy_o,
  output logic done_o
);
  logic run, tick, phase_end;

  i2cbc_tick #(.TICKS_PER_US(TICKS_PER_US)) u_tick (
    .clk(clk), .rst(rst), .run_i(run), .tick_o(tick)
  );

  i2cbc_interval #(.INTERVAL_US(INTERVAL_US)) u_ival (
    .clk(clk), .rst(rst), .run_i(run), .tick_i(tick), .phase_end_o(phase_end)
  );

  i2cbc_ctrl #(.NUM_PULSES(NUM_PULSES)) u_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i), .phase_end_i(phase_end),
    .run_o(run), .nack_force_o(nack_force_o), .scl_low_o(scl_low_o),
    .sda_low_o(sda_low_o), .busy_o(busy_o), .done_o(done_o)
  );
endmodule

// File: rtl/i2cbc_chk.sv
module i2cbc_chk #(
  parameter int TICKS_PER_US = 50,
  parameter int INTERVAL_US  = 20,
  parameter int NUM_PULSES   = 9
) (
  input logic clk,
  input logic rst,
  input logic start_i,
  input logic nack_force_o,
  input logic scl_low_o,
  input logic sda_low_o,
  input logic busy_o,
  input logic done_o
);
  localparam int PHASE = TICKS_PER_US * INTERVAL_US;

  int unsigned low_len_q;
  int unsigned pulses_q;
  logic        scl_prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_len_q  <= 0;
      pulses_q   <= 0;
      scl_prev_q <= 1'b0;
    end else begin
      low_len_q  <= scl_low_o ? low_len_q + 1 : 0;
      scl_prev_q <= scl_low_o;
      if (!busy_o) pulses_q <= 0;
      else if (scl_low_o && !scl_prev_q) pulses_q <= pulses_q + 1;
    end
  end

  // R1
  arm_nack_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> nack_force_o && !scl_low_o && !sda_low_o);

  // R2
  pulse_total_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> pulses_q == NUM_PULSES);

  // R3
  low_width_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(scl_low_o) |-> low_len_q == PHASE);

  // R5
  no_dual_drive_chk: assert property (@(posedge clk) disable iff (rst)
    !(scl_low_o && sda_low_o));

  // R6
  stop_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sda_low_o) |-> done_o && !scl_low_o);

  // R7
  done_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o && $past(busy_o));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> done_o);
endmodule

bind i2c_bus_clear i2cbc_chk #(
  .TICKS_PER_US(TICKS_PER_US), .INTERVAL_US(INTERVAL_US), .NUM_PULSES(NUM_PULSES)
) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .nack_force_o(nack_force_o),
  .scl_low_o(scl_low_o), .sda_low_o(sda_low_o), .busy_o(busy_o), .done_o(done_o)
);

// File: tb/tb_i2c_bus_clear.sv
module tb_i2c_bus_clear;
  localparam int TPU   = 2;
  localparam int IUS   = 3;
  localparam int NP    = 9;
  localparam int PHASE = TPU * IUS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic nack_force_o, scl_low_o, sda_low_o, busy_o, done_o;

  always #10 clk = ~clk;

  i2c_bus_clear #(.TICKS_PER_US(TPU), .INTERVAL_US(IUS), .NUM_PULSES(NP)) dut (
    .clk(clk), .rst(rst), .start_i(start_i), .nack_force_o(nack_force_o),
    .scl_low_o(scl_low_o), .sda_low_o(sda_low_o), .busy_o(busy_o), .done_o(done_o)
  );

  typedef struct {
    int unsigned cyc;
    logic [4:0]  v;   // {nack, scl_low, sda_low, busy, done}
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int unsigned cyc = 0;
  int          checks = 0;
  int          errors = 0;
  int          rises = 0;
  logic        scl_prev = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: pops every expected item that falls due in this cycle.
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].cyc == cyc) begin
      exp_t e;
      logic [4:0] got;
      e = sb.pop_front();
      got = {nack_force_o, scl_low_o, sda_low_o, busy_o, done_o};
      checks++;
      if (got !== e.v) begin
        errors++;
        $display("FAIL %s cyc %0d got %b exp %b", e.tag, cyc, got, e.v);
      end
    end
    if (!rst) begin
      if (scl_low_o && !scl_prev) rises++;
      scl_prev = scl_low_o;
    end
  end

  task automatic push(input int unsigned c, input logic [4:0] v, input string t);
    exp_t e;
    e.cyc = c; e.v = v; e.tag = t;
    sb.push_back(e);
  endtask

  // Driver: strobe start at a negedge and queue the full expected waveform.
  task automatic run_recovery(input bit noisy);
    int unsigned c;
    @(negedge clk);
    c = cyc + 1;
    rises = 0;
    start_i = 1'b1;
    push(c, 5'b10010, "R1"); c++;
    for (int k = 0; k < NP; k++) begin
      for (int i = 0; i < PHASE; i++) begin push(c, 5'b11010, "R3"); c++; end
      for (int i = 0; i < PHASE; i++) begin push(c, 5'b10010, "R4"); c++; end
    end
    for (int i = 0; i < PHASE; i++) begin push(c, 5'b10110, "R6"); c++; end
    push(c, 5'b00001, "R7"); c++;
    push(c, 5'b00000, "R7"); c++;
    if (noisy) begin
      for (int i = 0; i < 3; i++) begin push(c, 5'b00000, "R8"); c++; end
    end
    @(negedge clk);
    start_i = 1'b0;
    if (noisy) begin
      repeat (3) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      repeat (40) @(negedge clk);
      start_i = 1'b1;
      repeat (2) @(negedge clk);
      start_i = 1'b0;
    end
    while (sb.size() > 0) @(negedge clk);
    checks++;
    if (rises != NP) begin
      errors++;
      $display("FAIL R2 pulse count got %0d exp %0d", rises, NP);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    checks++;
    if ({nack_force_o, scl_low_o, sda_low_o, busy_o, done_o} !== 5'b0) begin
      errors++;
      $display("FAIL R9 reset got %b exp %b",
               {nack_force_o, scl_low_o, sda_low_o, busy_o, done_o}, 5'b0);
    end
    rst = 1'b0;
    repeat (2) @(negedge clk);
    checks++;
    if ({nack_force_o, scl_low_o, sda_low_o, busy_o, done_o} !== 5'b0) begin
      errors++;
      $display("FAIL R9 after reset got %b exp %b",
               {nack_force_o, scl_low_o, sda_low_o, busy_o, done_o}, 5'b0);
    end
    run_recovery(1'b0);
    repeat (4) @(negedge clk);
    run_recovery(1'b1);   // R8: strobes while busy
    repeat (2) @(negedge clk);
    run_recovery(1'b0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule